// File: doc/BRIEF.md
# Power-On Reset and Chip Mode Sequencer

This block brings a chip out of power-on reset in a fixed order once an external power-good signal says that all supplies have settled. Power-good is brought into the reference clock domain through a two-flop synchronizer. The synchronized level then releases an early reset tier, which serves logic that has to run before the rest of the chip. On the clock edge that releases this early tier, the block captures its configuration straps: a 2-bit chip mode, a boot select that picks PLL bypass or the PLL clock with a programmed ratio, and a select input that picks the reset vector. The captured values are then held until power is lost.

The system reset tier is released next. In bypass mode it follows the early tier after a short fixed delay and does not wait for the PLL. In PLL mode it is held until the PLL lock input has stayed high for a fixed number of reference cycles. When power-good falls, both reset tiers assert at once without waiting for a clock edge, and every captured output returns to zero.

Top module: `por_mode_seq`

## Requirements
- R1: Power-good passes through two synchronizer flops, then a registered early reset. `early_rst_o` stays high through the second rising reference edge after power-good rises and goes low at the third.
- R2: The mode strap is captured on the edge where `early_rst_o` falls. The codes are 00 functional, 01 scan, 10 memory self-test and 11 debug dump. `mode_onehot_o` has bit i set when the captured code equals i, and exactly one bit is set while the early reset is released.
- R3: The boot select (1 = PLL bypass) and the clock ratio strap are captured on that same edge and appear on `pll_bypass_o` and `clk_ratio_o`.
- R4: `reset_vector_o` is captured on that edge as VEC_BASE + sel * VEC_STRIDE, where sel is the reset-vector select strap.
- R5: Changes on any strap after capture have no effect on the outputs while power-good stays high.
- R6: In bypass mode, `sys_rst_o` falls on the second rising edge after the edge where `early_rst_o` falls, whatever the lock input does.
- R7: In PLL mode, `sys_rst_o` stays high until lock is seen. If lock is raised before rising edge k and held, `sys_rst_o` falls at edge k + LOCK_WAIT + 2.
- R8: In PLL mode, if lock drops before release, the lock count restarts from zero.
- R9: When power-good goes low, `early_rst_o` and `sys_rst_o` assert at once without a clock edge, and the mode, one-hot, bypass, ratio and vector outputs clear to zero.
- R10: `sys_rst_o` is never low while `early_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| pwr_good_i | input | 1 | Power-good from the board, asynchronous, low means reset |
| mode_strap_i | input | 2 | Chip mode strap |
| boot_bypass_i | input | 1 | Boot select, 1 = PLL bypass |
| clk_ratio_strap_i | input | RATIO_W | Clock ratio setting for PLL mode |
| vec_sel_strap_i | input | SEL_W | Reset vector select |
| pll_locked_i | input | 1 | PLL lock indication, asynchronous |
| early_rst_o | output | 1 | Pre-system reset, active high |
| sys_rst_o | output | 1 | System reset, active high |
| chip_mode_o | output | 2 | Captured mode code |
| mode_onehot_o | output | 4 | One-hot decode of the captured mode |
| pll_bypass_o | output | 1 | Captured bypass selection |
| clk_ratio_o | output | RATIO_W | Captured clock ratio |
| reset_vector_o | output | XLEN | Selected reset vector |

## Verification
The assertions check four ordering rules on every cycle. The system reset never releases ahead of the early reset. Captured configuration stays stable once the early reset is released. The mode decode stays one-hot in that time. In PLL mode, the system reset releases only after lock had been present. Only the bench scenarios can show the exact release cycles, the arithmetic of the vector selection, the count restart after a lock glitch, and the immediate assertion of both resets on power loss. The bench sweeps every mode, both boot selections and every vector select to cover these.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;
  typedef enum logic [1:0] {
    MODE_FUNC  = 2'b00,
    MODE_SCAN  = 2'b01,
    MODE_MBIST = 2'b10,
    MODE_DUMP  = 2'b11
  } chip_mode_e;

  typedef enum logic [1:0] {
    ST_HOLD,
    ST_LOCK,
    ST_REL,
    ST_RUN
  } rel_state_e;

  localparam int NUM_MODES = 4;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge arst_n_i) begin
          if (!arst_n_i) stage_q[0] <= 1'b0;
          else           stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge arst_n_i) begin
          if (!arst_n_i) stage_q[g] <= 1'b0;
          else           stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/por_strap_latch.sv
module por_strap_latch
  import por_seq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          RATIO_W    = 3,
  parameter int          SEL_W      = 2,
  parameter logic [XLEN-1:0] VEC_BASE   = '0,
  parameter logic [XLEN-1:0] VEC_STRIDE = '0
) (
  input  logic               clk_i,
  input  logic               pwr_good_i,
  input  logic               pg_sync_i,
  input  logic [1:0]         mode_strap_i,
  input  logic               boot_bypass_i,
  input  logic [RATIO_W-1:0] clk_ratio_strap_i,
  input  logic [SEL_W-1:0]   vec_sel_strap_i,
  output logic               early_rst_o,
  output logic [1:0]         chip_mode_o,
  output logic [NUM_MODES-1:0] mode_onehot_o,
  output logic               pll_bypass_o,
  output logic [RATIO_W-1:0] clk_ratio_o,
  output logic [XLEN-1:0]    reset_vector_o
);
  logic take;
  assign take = early_rst_o && pg_sync_i;

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) begin
      early_rst_o    <= 1'b1;
      chip_mode_o    <= MODE_FUNC;
      pll_bypass_o   <= 1'b0;
      clk_ratio_o    <= '0;
      reset_vector_o <= '0;
    end else if (take) begin
      early_rst_o    <= 1'b0;
      chip_mode_o    <= mode_strap_i;
      pll_bypass_o   <= boot_bypass_i;
      clk_ratio_o    <= clk_ratio_strap_i;
      reset_vector_o <= VEC_BASE + VEC_STRIDE * XLEN'(vec_sel_strap_i);
    end
  end

  generate
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_dec
      always_ff @(posedge clk_i or negedge pwr_good_i) begin
        if (!pwr_good_i) mode_onehot_o[m] <= 1'b0;
        else if (take)   mode_onehot_o[m] <= (mode_strap_i == 2'(m));
      end
    end
  endgenerate
endmodule

// File: rtl/por_release_seq.sv
module por_release_seq
  import por_seq_pkg::*;
#(
  parameter int LOCK_WAIT = 16
) (
  input  logic clk_i,
  input  logic pwr_good_i,
  input  logic early_rst_i,
  input  logic bypass_i,
  input  logic lock_sync_i,
  output logic sys_rst_o
);
  localparam int CNT_W = $clog2(LOCK_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_WAIT - 1);

  rel_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) begin
      state_q   <= ST_HOLD;
      cnt_q     <= '0;
      sys_rst_o <= 1'b1;
    end else begin
      case (state_q)
        ST_HOLD: if (!early_rst_i) state_q <= bypass_i ? ST_REL : ST_LOCK;
        ST_LOCK: begin
          if (!lock_sync_i)          cnt_q   <= '0;
          else if (cnt_q == CNT_LAST) state_q <= ST_REL;
          else                       cnt_q   <= cnt_q + 1'b1;
        end
        ST_REL: begin
          sys_rst_o <= 1'b0;
          state_q   <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/por_mode_seq.sv
module por_mode_seq
  import por_seq_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          RATIO_W    = 3,
  parameter int          SEL_W      = 2,
  parameter int          LOCK_WAIT  = 16,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'h0000_1000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0100
) (
  input  logic               clk_ref_i,
  input  logic               pwr_good_i,
  input  logic [1:0]         mode_strap_i,
  input  logic               boot_bypass_i,
  input  logic [RATIO_W-1:0] clk_ratio_strap_i,
  input  logic [SEL_W-1:0]   vec_sel_strap_i,
  input  logic               pll_locked_i,
  output logic               early_rst_o,
  output logic               sys_rst_o,
  output logic [1:0]         chip_mode_o,
  output logic [3:0]         mode_onehot_o,
  output logic               pll_bypass_o,
  output logic [RATIO_W-1:0] clk_ratio_o,
  output logic [XLEN-1:0]    reset_vector_o
);
  logic pg_sync;
  logic lock_sync;

  por_sync #(.STAGES(2)) i_pg_sync (
    .clk_i(clk_ref_i), .arst_n_i(pwr_good_i), .d_i(1'b1), .q_o(pg_sync)
  );

  por_sync #(.STAGES(2)) i_lock_sync (
    .clk_i(clk_ref_i), .arst_n_i(pwr_good_i), .d_i(pll_locked_i), .q_o(lock_sync)
  );

  por_strap_latch #(
    .XLEN(XLEN), .RATIO_W(RATIO_W), .SEL_W(SEL_W),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) i_latch (
    .clk_i(clk_ref_i),
    .pwr_good_i(pwr_good_i),
    .pg_sync_i(pg_sync),
    .mode_strap_i(mode_strap_i),
    .boot_bypass_i(boot_bypass_i),
    .clk_ratio_strap_i(clk_ratio_strap_i),
    .vec_sel_strap_i(vec_sel_strap_i),
    .early_rst_o(early_rst_o),
    .chip_mode_o(chip_mode_o),
    .mode_onehot_o(mode_onehot_o),
    .pll_bypass_o(pll_bypass_o),
    .clk_ratio_o(clk_ratio_o),
    .reset_vector_o(reset_vector_o)
  );

  por_release_seq #(.LOCK_WAIT(LOCK_WAIT)) i_rel (
    .clk_i(clk_ref_i),
    .pwr_good_i(pwr_good_i),
    .early_rst_i(early_rst_o),
    .bypass_i(pll_bypass_o),
    .lock_sync_i(lock_sync),
    .sys_rst_o(sys_rst_o)
  );
endmodule

// File: rtl/por_mode_seq_chk.sv
module por_mode_seq_chk #(
  parameter int XLEN    = 32,
  parameter int RATIO_W = 3
) (
  input logic               clk_ref_i,
  input logic               pwr_good_i,
  input logic               pll_locked_i,
  input logic               early_rst_o,
  input logic               sys_rst_o,
  input logic [1:0]         chip_mode_o,
  input logic [3:0]         mode_onehot_o,
  input logic               pll_bypass_o,
  input logic [RATIO_W-1:0] clk_ratio_o,
  input logic [XLEN-1:0]    reset_vector_o
);
  AST_SYS_AFTER_EARLY: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
    early_rst_o |-> sys_rst_o); // R10

  AST_EARLY_LEADS: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
    $fell(early_rst_o) |-> sys_rst_o); // R10

  AST_CFG_HELD: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
    (!early_rst_o && !$past(early_rst_o)) |->
      ($stable(chip_mode_o) && $stable(mode_onehot_o) && $stable(pll_bypass_o) &&
       $stable(clk_ratio_o) && $stable(reset_vector_o))); // R5

  AST_MODE_ONEHOT: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
    !early_rst_o |-> ($countones(mode_onehot_o) == 1)); // R2

  AST_LOCK_BEFORE_REL: assert property (@(posedge clk_ref_i) disable iff (!pwr_good_i)
    ($fell(sys_rst_o) && !pll_bypass_o) |-> $past(pll_locked_i, 4)); // R7

  AST_PG_LOSS_RESETS: assert property (@(posedge clk_ref_i)
    !pwr_good_i |=> (early_rst_o && sys_rst_o)); // R9
endmodule

bind por_mode_seq por_mode_seq_chk #(.XLEN(XLEN), .RATIO_W(RATIO_W)) i_chk (
  .clk_ref_i(clk_ref_i),
  .pwr_good_i(pwr_good_i),
  .pll_locked_i(pll_locked_i),
  .early_rst_o(early_rst_o),
  .sys_rst_o(sys_rst_o),
  .chip_mode_o(chip_mode_o),
  .mode_onehot_o(mode_onehot_o),
  .pll_bypass_o(pll_bypass_o),
  .clk_ratio_o(clk_ratio_o),
  .reset_vector_o(reset_vector_o)
);

// File: tb/test_por_mode_seq.sv
module test_por_mode_seq;
  localparam int CLK_P     = 10;
  localparam int XLEN      = 32;
  localparam int RATIO_W   = 3;
  localparam int SEL_W     = 2;
  localparam int LOCK_WAIT = 4;
  localparam logic [XLEN-1:0] VBASE   = 32'h0000_2000;
  localparam logic [XLEN-1:0] VSTRIDE = 32'h0000_0040;

  logic               clk = 1'b0;
  logic               pg = 1'b0;
  logic [1:0]         mode_s = '0;
  logic               byp_s = 1'b0;
  logic [RATIO_W-1:0] ratio_s = '0;
  logic [SEL_W-1:0]   sel_s = '0;
  logic               lock = 1'b0;
  logic               early_rst, sys_rst, pll_bypass;
  logic [1:0]         chip_mode;
  logic [3:0]         onehot;
  logic [RATIO_W-1:0] ratio;
  logic [XLEN-1:0]    vec;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  por_mode_seq #(
    .XLEN(XLEN), .RATIO_W(RATIO_W), .SEL_W(SEL_W), .LOCK_WAIT(LOCK_WAIT),
    .VEC_BASE(VBASE), .VEC_STRIDE(VSTRIDE)
  ) i_por_mode_seq (
    .clk_ref_i(clk), .pwr_good_i(pg), .mode_strap_i(mode_s),
    .boot_bypass_i(byp_s), .clk_ratio_strap_i(ratio_s), .vec_sel_strap_i(sel_s),
    .pll_locked_i(lock), .early_rst_o(early_rst), .sys_rst_o(sys_rst),
    .chip_mode_o(chip_mode), .mode_onehot_o(onehot), .pll_bypass_o(pll_bypass),
    .clk_ratio_o(ratio), .reset_vector_o(vec)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req, input int m, input bit b, input int r, input int s);
    chk({req, " mode"}, 64'(chip_mode), 64'(m));
    chk({req, " onehot"}, 64'(onehot), 64'(1 << m));
    chk({req, " bypass"}, 64'(pll_bypass), 64'(b));
    chk({req, " ratio"}, 64'(ratio), 64'(r));
    chk({req, " vector"}, 64'(vec), 64'(VBASE) + 64'(VSTRIDE) * 64'(s));
  endtask

  task automatic count_release(input string req);
    int n = 0;
    while (n < 60) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!sys_rst) break;
    end
    chk(req, 64'(n), 64'(LOCK_WAIT + 3));
  endtask

  task automatic power_cycle(input int m, input bit b, input int r, input int s, input bit glitch);
    @(negedge clk);
    pg = 1'b0; lock = 1'b0;
    mode_s = 2'(m); byp_s = b; ratio_s = RATIO_W'(r); sel_s = SEL_W'(s);
    repeat (2) @(negedge clk);
    pg = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 early held two edges", 64'(early_rst), 64'd1);
    @(posedge clk); @(negedge clk);
    chk("R1 early released third edge", 64'(early_rst), 64'd0);
    chk("R10 sys still held", 64'(sys_rst), 64'd1);
    chk_cfg("R2 R3 R4 capture", m, b, r, s);
    mode_s = ~mode_s; byp_s = ~byp_s; ratio_s = ~ratio_s; sel_s = ~sel_s;
    if (b) begin
      lock = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R6 sys held one edge", 64'(sys_rst), 64'd1);
      @(posedge clk); @(negedge clk);
      chk("R6 bypass release without lock", 64'(sys_rst), 64'd0);
    end else begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R7 sys held without lock", 64'(sys_rst), 64'd1);
      if (glitch) begin
        lock = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); lock = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R8 glitch does not release", 64'(sys_rst), 64'd1);
        lock = 1'b1;
        count_release("R8 count restarts after glitch");
      end else begin
        lock = 1'b1;
        count_release("R7 release delay after lock");
      end
    end
    chk_cfg("R5 straps ignored after capture", m, b, r, s);
    @(negedge clk);
    #2 pg = 1'b0;
    #1;
    chk("R9 early async", 64'(early_rst), 64'd1);
    chk("R9 sys async", 64'(sys_rst), 64'd1);
    chk("R9 cleared cfg", {31'd0, pll_bypass, ratio, onehot, chip_mode, vec}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset early", 64'(early_rst), 64'd1);
    chk("R9 reset sys", 64'(sys_rst), 64'd1);
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < (1 << SEL_W); s++)
          power_cycle(m, b[0], (m * 3 + s + b) % (1 << RATIO_W), s, 1'b0);
    for (int m = 0; m < 4; m++)
      power_cycle(m, 1'b0, m + 2, 3 - m, 1'b1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule